// File: doc/BRIEF.md
# Dual-Mode Serial Command Word Receiver

This block takes 16-bit command words from a three-wire serial port (bit clock, data line, frame strobe) into a system clock domain. Each word travels most significant bit first. The block hands each word on as a 4-bit address and a 12-bit data field, and flags it with a strobe that lasts one system clock. Downstream register decode consumes the word. This block does no decoding of its own.

A static mode input chooses between two framing rules. In controller framing, the frame strobe must stay low across the whole word, a word cut short is dropped, and a finished word is released only when the strobe rises again. In DSP framing, a short low pulse on the strobe opens a word, and the word is released on its sixteenth falling bit-clock edge, whatever the strobe is doing by then. A cascade output repeats the data line sixteen bit clocks late, so that several receivers can share one port. An enable input gates this output.

The three serial pins pass through two-flop synchronizers, and edges are found in the system domain. Each bit-clock phase must last at least two system clocks. The frame strobe must fall at least one system clock before the first falling bit-clock edge of a word. The framing state machine has three states. `ST_IDLE` waits for a word to start. `ST_SHIFT` collects bits. `ST_HOLD` is used only in controller framing: it holds a complete word until the strobe rises. The transitions are:
- start: `ST_IDLE` to `ST_SHIFT` on a strobe fall.
- restart: `ST_SHIFT` to `ST_SHIFT`, count cleared, on a strobe fall.
- abort: `ST_SHIFT` to `ST_IDLE` on a strobe rise in controller framing.
- full: `ST_SHIFT` to `ST_HOLD` on the sixteenth bit in controller framing.
- finish: `ST_SHIFT` to `ST_IDLE` on the sixteenth bit in DSP framing, releasing the word.
- release: `ST_HOLD` to `ST_IDLE` on a strobe rise, releasing the word.
- reopen: `ST_HOLD` to `ST_SHIFT` on a strobe fall.

Top module: `serial_word_rx`

## Requirements
- R1: A released word arrives MSB first. Its bits 15..12 appear on `word_addr`, with bit 15 as the address MSB, and its bits 11..0 appear on `word_data`.
- R2: Each data bit is the level of `din_pin` at the falling edge of `sclk_pin`. Changes to `din_pin` during the low phase of the clock have no effect.
- R3: With `mode_mcu`=1, a rise of `fs_pin` before the sixteenth falling clock edge of a word drops that word, and no strobe is produced for it.
- R4: With `mode_mcu`=1, a complete word is released only after `fs_pin` rises. No strobe occurs while `fs_pin` stays low. Falling clock edges after the sixteenth do not change the held word.
- R5: With `mode_mcu`=0, a low pulse on `fs_pin` opens a word. `fs_pin` may return high at once, or stay low. The word is released after its sixteenth falling clock edge.
- R6: A fall of `fs_pin` while a word is in progress restarts the bit count. The word that is released holds the 16 bits that follow that fall.
- R7: After the n-th falling clock edge since reset, `dout` (with `dout_en`=1) shows the bit captured at edge n-15, or 0 if that edge number is not positive. A receiver downstream that samples on the next fall therefore sees the stream 16 bit clocks late.
- R8: While `dout_en`=0, `dout` is 0.
- R9: `word_valid` is high for exactly one system clock per released word.
- R10: After reset, `word_valid` and `dout` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_pin | input | 1 | Serial bit clock (asynchronous) |
| fs_pin | input | 1 | Frame strobe, active low (asynchronous) |
| din_pin | input | 1 | Serial data in (asynchronous) |
| mode_mcu | input | 1 | 1 = controller framing, 0 = DSP framing (static) |
| dout_en | input | 1 | Enable for the cascade output |
| word_valid | output | 1 | One-cycle strobe for a released word |
| word_addr | output | ADDR_W | Address field of the released word |
| word_data | output | WORD_W-ADDR_W | Data field of the released word |
| dout | output | 1 | Cascade data, 16 bit clocks late |

## Verification
The bench aims at the framing edges. It sends a controller word cut off after ten bits, which a design without the abort path would release as a garbled word. It holds the strobe low past the sixteenth edge and adds extra clocks; a design that released early or kept shifting would deliver a wrong or premature word. It sends a DSP word with a strobe pulse that ends before the first bit, which a level-sensitive design would never complete. It restarts a DSP word in the middle; a design that ignores the restart would release a mix of old and new bits. It toggles the data line during the low clock phase, which exposes capture on the wrong edge. It checks the cascade output before every falling edge over back-to-back words; an off-by-one delay line would shift the replayed word by one bit.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } rx_state_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= {STAGES{RST_VAL[i]}};
            end else begin
                pipe <= {pipe[STAGES-2:0], d[i]};
            end
        end

        assign q[i] = pipe[STAGES-1];
    end

endmodule

// File: rtl/srx_edges.sv
module srx_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic fs_s,
    output logic sclk_fall,
    output logic fs_rise,
    output logic fs_fall
);

    logic sclk_d;
    logic fs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b1;
            fs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            fs_d   <= fs_s;
        end
    end

    assign sclk_fall = sclk_d & ~sclk_s;
    assign fs_rise   = ~fs_d & fs_s;
    assign fs_fall   = fs_d & ~fs_s;

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_mcu,
    input  logic                     sclk_fall,
    input  logic                     fs_rise,
    input  logic                     fs_fall,
    input  logic                     din_bit,
    output logic                     word_valid,
    output logic [ADDR_W-1:0]        word_addr,
    output logic [WORD_W-ADDR_W-1:0] word_data
);

    localparam int DATA_W = WORD_W - ADDR_W;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    rx_state_t         state_r, state_n;
    logic [CNT_W-1:0]  cnt_r, cnt_n;
    logic [WORD_W-1:0] shreg_r, shreg_n;
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] commit_word;
    logic              commit;

    assign shifted = {shreg_r[WORD_W-2:0], din_bit};

    always_comb begin
        state_n     = state_r;
        cnt_n       = cnt_r;
        shreg_n     = shreg_r;
        commit      = 1'b0;
        commit_word = shreg_r;
        unique case (state_r)
            ST_IDLE: begin
                if (fs_fall) begin
                    state_n = ST_SHIFT;
                    cnt_n   = '0;
                end
            end
            ST_SHIFT: begin
                if (mode_mcu && fs_rise) begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else if (fs_fall) begin
                    cnt_n = '0;
                end else if (sclk_fall) begin
                    shreg_n = shifted;
                    if (cnt_r == LAST_BIT) begin
                        cnt_n = '0;
                        if (mode_mcu) begin
                            state_n = ST_HOLD;
                        end else begin
                            state_n     = ST_IDLE;
                            commit      = 1'b1;
                            commit_word = shifted;
                        end
                    end else begin
                        cnt_n = cnt_r + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (fs_rise) begin
                    state_n = ST_IDLE;
                    commit  = 1'b1;
                end else if (fs_fall) begin
                    state_n = ST_SHIFT;
                    cnt_n   = '0;
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_r <= ST_IDLE;
            cnt_r   <= '0;
            shreg_r <= '0;
        end else begin
            state_r <= state_n;
            cnt_r   <= cnt_n;
            shreg_r <= shreg_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_addr  <= '0;
            word_data  <= '0;
        end else begin
            word_valid <= commit;
            if (commit) begin
                word_addr <= commit_word[WORD_W-1 -: ADDR_W];
                word_data <= commit_word[DATA_W-1:0];
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R9
    AST_MCU_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_mcu && state_r == ST_SHIFT && fs_rise) |=> !word_valid); // R3
    AST_MCU_RELEASE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && mode_mcu) |-> $past(fs_rise)); // R4
    AST_DSP_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !mode_mcu) |-> $past(sclk_fall)); // R5
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_r == ST_SHIFT && fs_fall) |=> (cnt_r == '0)); // R6
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_data)); // R9

endmodule

// File: rtl/srx_chain.sv
module srx_chain #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_fall,
    input  logic din_bit,
    input  logic dout_en,
    output logic dout
);

    logic [DEPTH-1:0] chain_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_r <= '0;
        end else if (sclk_fall) begin
            chain_r <= {chain_r[DEPTH-2:0], din_bit};
        end
    end

    assign dout = dout_en & chain_r[DEPTH-1];

    AST_CHAIN_MOVES_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(chain_r)); // R7

endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk_pin,
    input  logic                     fs_pin,
    input  logic                     din_pin,
    input  logic                     mode_mcu,
    input  logic                     dout_en,
    output logic                     word_valid,
    output logic [ADDR_W-1:0]        word_addr,
    output logic [WORD_W-ADDR_W-1:0] word_data,
    output logic                     dout
);

    localparam int DATA_W = WORD_W - ADDR_W;

    logic [2:0] pins_s;
    logic       sclk_fall;
    logic       fs_rise;
    logic       fs_fall;

    srx_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b011)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({din_pin, fs_pin, sclk_pin}),
        .q     (pins_s)
    );

    srx_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[0]),
        .fs_s      (pins_s[1]),
        .sclk_fall (sclk_fall),
        .fs_rise   (fs_rise),
        .fs_fall   (fs_fall)
    );

    srx_frame_fsm #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_mcu   (mode_mcu),
        .sclk_fall  (sclk_fall),
        .fs_rise    (fs_rise),
        .fs_fall    (fs_fall),
        .din_bit    (pins_s[2]),
        .word_valid (word_valid),
        .word_addr  (word_addr),
        .word_data  (word_data)
    );

    srx_chain #(
        .DEPTH (WORD_W)
    ) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_fall (sclk_fall),
        .din_bit   (pins_s[2]),
        .dout_en   (dout_en),
        .dout      (dout)
    );

    AST_DOUT_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!dout_en && !$past(dout_en)) |-> !dout); // R8

    initial begin
        AST_DATA_WIDTH: assert (DATA_W > 0 && SYNC_STAGES >= 2); // R1
    end

endmodule

// File: tb/serial_word_rx_test.sv
module serial_word_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_pin = 1'b1;
    logic        fs_pin = 1'b1;
    logic        din_pin = 1'b0;
    logic        mode_mcu = 1'b1;
    logic        dout_en = 1'b0;
    logic        word_valid;
    logic [3:0]  word_addr;
    logic [11:0] word_data;
    logic        dout;

    int          checks = 0;
    int          errors = 0;
    int          valid_seen = 0;
    int          expected_total = 0;
    logic        prev_valid = 1'b0;
    logic        chk_dout = 1'b0;
    logic [15:0] exp_q[$];
    logic        hist[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_word_rx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_pin   (sclk_pin),
        .fs_pin     (fs_pin),
        .din_pin    (din_pin),
        .mode_mcu   (mode_mcu),
        .dout_en    (dout_en),
        .word_valid (word_valid),
        .word_addr  (word_addr),
        .word_data  (word_data),
        .dout       (dout)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid) begin
                valid_seen++;
                check(!prev_valid, "R9 strobe width", 32'(prev_valid), 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected word", {16'h0, word_addr, word_data}, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(word_addr == e[15:12], "R1 address", 32'(word_addr), 32'(e[15:12]));
                    check(word_data == e[11:0], "R1 data", 32'(word_data), 32'(e[11:0]));
                end
            end
            prev_valid = word_valid;
        end
    end

    task automatic send_bit(input logic b);
        logic exp_d;
        if (chk_dout) begin
            exp_d = 1'b0;
            if (dout_en && hist.size() >= 16) exp_d = hist[hist.size() - 16];
            check(dout == exp_d, dout_en ? "R7 cascade bit" : "R8 cascade off", 32'(dout), 32'(exp_d));
        end
        din_pin = b;
        wait_clks(HALF);
        sclk_pin = 1'b0;
        hist.push_back(b);
        wait_clks(1);
        din_pin = ~b;  // R2: low-phase change must not be captured
        wait_clks(HALF - 1);
        sclk_pin = 1'b1;
    endtask

    task automatic send_mcu(input logic [15:0] w, input int extra);
        int seen0;
        fs_pin = 1'b0;
        wait_clks(HALF);
        seen0 = valid_seen;
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
        for (int i = 0; i < extra; i++) send_bit(1'b1);
        wait_clks(3 * HALF);
        check(valid_seen == seen0, "R4 no strobe while FS low", 32'(valid_seen), 32'(seen0));
        exp_q.push_back(w);
        expected_total++;
        fs_pin = 1'b1;
        wait_clks(3 * HALF);
    endtask

    task automatic send_mcu_abort(input logic [15:0] w, input int nbits);
        int seen0;
        seen0 = valid_seen;
        fs_pin = 1'b0;
        wait_clks(HALF);
        for (int i = 15; i > 15 - nbits; i--) send_bit(w[i]);
        fs_pin = 1'b1;
        wait_clks(4 * HALF);
        check(valid_seen == seen0, "R3 dropped word", 32'(valid_seen), 32'(seen0));
    endtask

    task automatic send_dsp(input logic [15:0] w, input bit hold_low, input int pre_bits);
        fs_pin = 1'b0;
        wait_clks(2);
        if (!hold_low) fs_pin = 1'b1;
        wait_clks(HALF);
        for (int i = 0; i < pre_bits; i++) send_bit(~w[i]);
        if (pre_bits > 0) begin
            fs_pin = 1'b0;  // R6 restart
            wait_clks(2);
            if (!hold_low) fs_pin = 1'b1;
            wait_clks(HALF);
        end
        for (int i = 15; i >= 0; i--) begin
            if (i == 0) begin
                exp_q.push_back(w);
                expected_total++;
            end
            send_bit(w[i]);
        end
        fs_pin = 1'b1;
        wait_clks(3 * HALF);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        dout_en = 1'b1;
        wait_clks(5);
        check(word_valid == 1'b0, "R10 valid after reset", 32'(word_valid), 0);
        check(dout == 1'b0, "R10 dout after reset", 32'(dout), 0);
        rst_n = 1'b1;
        wait_clks(5);
        check(word_valid == 1'b0, "R10 valid idle", 32'(word_valid), 0);

        // controller framing
        mode_mcu = 1'b1;
        send_mcu(16'hA5C3, 0);                 // R1 R2 R4
        send_mcu(16'h0001, 0);
        send_mcu_abort(16'hFFFF, 10);          // R3
        send_mcu(16'h8E70, 0);
        send_mcu_abort(16'h1234, 15);          // R3 at last-but-one bit
        send_mcu(16'h3C5A, 3);                 // R4 extra clocks ignored

        // DSP framing
        mode_mcu = 1'b0;
        send_dsp(16'h7F01, 1'b0, 0);           // R5 short pulse
        send_dsp(16'hC0DE, 1'b1, 0);           // R5 held low
        send_dsp(16'h4B2D, 1'b0, 5);           // R6 restart

        // cascade output
        chk_dout = 1'b1;
        dout_en  = 1'b1;
        send_dsp(16'h9A6F, 1'b0, 0);           // R7
        send_dsp(16'h15E8, 1'b0, 0);           // R7
        dout_en  = 1'b0;
        send_dsp(16'hFFFF, 1'b0, 0);           // R8
        chk_dout = 1'b0;

        wait_clks(10);
        check(exp_q.size() == 0, "R5 all words released", 32'(exp_q.size()), 0);
        check(valid_seen == expected_total, "R9 strobe count", 32'(valid_seen), 32'(expected_total));
        finish_run();
    end

endmodule